// File: doc/BRIEF.md
# Two-Dimensional Scratchpad Block Mover

This block copies bytes between a 24-bit byte-addressed external DRAM and a 4 KiB on-chip scratchpad. The scratchpad has two banks, one for instructions and one for data. A transfer is a sequence of rows. Every row holds the same number of bytes, rounded up to whole 8-byte units. Between two rows a programmable gap is added to the DRAM address, but no gap follows the final row. The scratchpad side simply continues after each row and wraps at 4 KiB.

Software sets up a transfer in three steps:
- It writes a scratchpad address (offset plus bank bit) into a shadow register.
- It writes a DRAM address into a second shadow register.
- It writes a control word through one of two start strobes. One strobe copies DRAM into the scratchpad. The other copies the scratchpad into DRAM.

The engine latches the shadow copies when the transfer starts. It then moves one byte per accepted beat. When the transfer finishes, it exposes the final advanced addresses and a fixed control readback on its readback ports.

The byte path uses a valid/ready beat. `beat_valid` stays high for the whole transfer. A byte moves only on a cycle where both `beat_valid` and `beat_ready` are high. While `beat_ready` is low, both addresses are held, both write strobes are low, and the transfer simply waits. Source data is read combinationally in the same cycle: `dram_rdata` for reads into the scratchpad, `sp_rdata` for writes out to DRAM.

Top module: `sdma_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `rd_loc`, `rd_dram` and `rd_ctrl` read 0.
- R2: The control word holds three fields: length in bits [11:0], row count in bits [19:12] and skip in bits [31:20]. A row holds ((length>>3)+1)*8 bytes. A transfer has count+1 rows. Exactly rows*rowbytes beats are accepted before `busy` falls.
- R3: The first beat uses the shadow scratchpad offset with bits [2:0] cleared and the shadow DRAM address with bits [2:0] cleared.
- R4: Each accepted beat advances `sp_addr` by one, wrapping modulo 4096. `sp_bank` equals bit 12 of the scratchpad address latched at start.
- R5: Inside a row, `dram_addr` advances by one per beat. The next row starts at (row start + rowbytes + skip) with bits [2:0] cleared, taken modulo 2^24. No skip is added after the last row.
- R6: `start_rd` starts a DRAM-to-scratchpad transfer: `sp_we` is high on each beat and `sp_wdata` equals `dram_rdata`. `start_wr` starts a scratchpad-to-DRAM transfer: `dram_we` is high on each beat and `dram_wdata` equals `sp_rdata`. If both strobes are high together, `start_rd` wins. The two write strobes are never high together.
- R7: While `beat_ready` is low during a transfer, both write strobes are low and both addresses hold their values.
- R8: `done` is high for exactly one cycle, the cycle after the last beat is accepted, and `busy` is low in that cycle.
- R9: A start strobe while `busy` is high is ignored. The running transfer, its beat count and `rd_ctrl` are unaffected.
- R10: Writes to the shadow address registers do not change `rd_loc` or `rd_dram`. One cycle after `done`, `rd_loc` holds {bank, final offset} and `rd_dram` holds the final DRAM address.
- R11: An accepted start makes `rd_ctrl` read the written control word. One cycle after `done`, `rd_ctrl` reads {skip, 20'h00FF8}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wdata | input | 32 | Write data for address registers and control word |
| wr_loc | input | 1 | Load shadow scratchpad address (bit 12 bank, bits 11:0 offset) |
| wr_dram | input | 1 | Load shadow DRAM address (bits 23:0) |
| start_rd | input | 1 | Control word write that starts DRAM-to-scratchpad |
| start_wr | input | 1 | Control word write that starts scratchpad-to-DRAM |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| beat_valid | output | 1 | Byte beat offered |
| beat_ready | input | 1 | Byte beat accepted by both memories |
| sp_bank | output | 1 | Scratchpad bank select (1 instruction, 0 data) |
| sp_addr | output | 12 | Scratchpad byte offset |
| sp_we | output | 1 | Scratchpad byte write strobe |
| sp_wdata | output | 8 | Scratchpad write byte |
| sp_rdata | input | 8 | Scratchpad read byte (combinational) |
| dram_addr | output | 24 | DRAM byte address |
| dram_we | output | 1 | DRAM byte write strobe |
| dram_wdata | output | 8 | DRAM write byte |
| dram_rdata | input | 8 | DRAM read byte (combinational) |
| rd_loc | output | 13 | Visible scratchpad address readback |
| rd_dram | output | 24 | Visible DRAM address readback |
| rd_ctrl | output | 32 | Control word readback |

## Verification
A wrong row counter or wrong length rounding shows up first as a mismatch in when `busy` falls. The last beat either comes early, so `done` rises too soon, or `beat_valid` is still high when `done` is expected. A faulty DRAM cursor shows on `dram_addr` at the first beat of the second row, so it is visible within one row. A lost wrap or a bad bank bit shows on `sp_addr`/`sp_bank` at the exact beat that crosses offset 4095. Readback mistakes appear on the cycle after `done`. Ignored-start faults appear on `rd_ctrl` one cycle after the stray strobe.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic {
    DIR_TO_SP   = 1'b0,
    DIR_FROM_SP = 1'b1
  } sdma_dir_e;

  localparam int ALIGN_BITS = 3;
endpackage

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int OFF_W   = 12,
  parameter int DADDR_W = 24,
  parameter int LEN_W   = 12,
  parameter int CNT_W   = 8,
  parameter int SKIP_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  sdma_dir_e          start_dir,
  input  logic [OFF_W:0]     sh_loc,
  input  logic [DADDR_W-1:0] sh_dram,
  input  logic [LEN_W-1:0]   len_f,
  input  logic [CNT_W-1:0]   cnt_f,
  input  logic [SKIP_W-1:0]  skip_f,
  input  logic               beat_ready,
  output logic               busy,
  output logic               done,
  output logic               accept,
  output logic               beat,
  output sdma_dir_e          dir,
  output logic               bank,
  output logic [OFF_W-1:0]   loc_ptr,
  output logic [DADDR_W-1:0] dram_ptr
);
  localparam int A = ALIGN_BITS;

  logic [LEN_W-1:0]   idx_q, last_idx_q;
  logic [CNT_W-1:0]   rows_left_q;
  logic [SKIP_W-1:0]  skip_q;
  logic               row_end, last_beat;
  logic [DADDR_W-1:0] dram_step;

  assign accept    = start & ~busy;
  assign beat      = busy & beat_ready;
  assign row_end   = (idx_q == last_idx_q);
  assign last_beat = beat & row_end & (rows_left_q == '0);

  // gap only between rows, never after the final one
  always_comb begin
    dram_step = dram_ptr + DADDR_W'(1);
    if (row_end && rows_left_q != '0)
      dram_step = dram_step + DADDR_W'(skip_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      dir         <= DIR_TO_SP;
      bank        <= 1'b0;
      loc_ptr     <= '0;
      dram_ptr    <= '0;
      idx_q       <= '0;
      last_idx_q  <= '0;
      rows_left_q <= '0;
      skip_q      <= '0;
    end else begin
      done <= last_beat;
      if (accept) begin
        busy        <= 1'b1;
        dir         <= start_dir;
        bank        <= sh_loc[OFF_W];
        loc_ptr     <= {sh_loc[OFF_W-1:A], {A{1'b0}}};
        dram_ptr    <= {sh_dram[DADDR_W-1:A], {A{1'b0}}};
        idx_q       <= '0;
        last_idx_q  <= {len_f[LEN_W-1:A], {A{1'b1}}};
        rows_left_q <= cnt_f;
        skip_q      <= skip_f;
      end else if (beat) begin
        loc_ptr <= loc_ptr + OFF_W'(1);
        if (row_end) begin
          idx_q    <= '0;
          dram_ptr <= {dram_step[DADDR_W-1:A], {A{1'b0}}};
          if (rows_left_q == '0) busy <= 1'b0;
          else rows_left_q <= rows_left_q - CNT_W'(1);
        end else begin
          idx_q    <= idx_q + LEN_W'(1);
          dram_ptr <= dram_step;
        end
      end
    end
  end
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs #(
  parameter int OFF_W   = 12,
  parameter int DADDR_W = 24,
  parameter int LEN_W   = 12,
  parameter int CNT_W   = 8,
  parameter int SKIP_W  = 12,
  localparam int FIELD_W = LEN_W + CNT_W,
  localparam int CTRL_W  = FIELD_W + SKIP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CTRL_W-1:0]  reg_wdata,
  input  logic               wr_loc,
  input  logic               wr_dram,
  input  logic               accept,
  input  logic               done,
  input  logic               fin_bank,
  input  logic [OFF_W-1:0]   fin_loc,
  input  logic [DADDR_W-1:0] fin_dram,
  output logic [OFF_W:0]     sh_loc,
  output logic [DADDR_W-1:0] sh_dram,
  output logic [OFF_W:0]     rd_loc,
  output logic [DADDR_W-1:0] rd_dram,
  output logic [CTRL_W-1:0]  rd_ctrl
);
  localparam logic [FIELD_W-1:0] DONE_LOW = FIELD_W'((1 << LEN_W) - 8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_loc  <= '0;
      sh_dram <= '0;
      rd_loc  <= '0;
      rd_dram <= '0;
      rd_ctrl <= '0;
    end else begin
      if (wr_loc)  sh_loc  <= reg_wdata[OFF_W:0];
      if (wr_dram) sh_dram <= reg_wdata[DADDR_W-1:0];
      if (accept) rd_ctrl <= reg_wdata;
      else if (done) rd_ctrl <= {rd_ctrl[CTRL_W-1:FIELD_W], DONE_LOW};
      if (done) begin
        rd_loc  <= {fin_bank, fin_loc};
        rd_dram <= fin_dram;
      end
    end
  end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int OFF_W   = 12,
  parameter int DADDR_W = 24,
  parameter int LEN_W   = 12,
  parameter int CNT_W   = 8,
  parameter int SKIP_W  = 12,
  localparam int CTRL_W = LEN_W + CNT_W + SKIP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CTRL_W-1:0]  reg_wdata,
  input  logic               wr_loc,
  input  logic               wr_dram,
  input  logic               start_rd,
  input  logic               start_wr,
  output logic               busy,
  output logic               done,
  output logic               beat_valid,
  input  logic               beat_ready,
  output logic               sp_bank,
  output logic [OFF_W-1:0]   sp_addr,
  output logic               sp_we,
  output logic [7:0]         sp_wdata,
  input  logic [7:0]         sp_rdata,
  output logic [DADDR_W-1:0] dram_addr,
  output logic               dram_we,
  output logic [7:0]         dram_wdata,
  input  logic [7:0]         dram_rdata,
  output logic [OFF_W:0]     rd_loc,
  output logic [DADDR_W-1:0] rd_dram,
  output logic [CTRL_W-1:0]  rd_ctrl
);
  logic [OFF_W:0]     sh_loc;
  logic [DADDR_W-1:0] sh_dram;
  logic               accept, beat;
  sdma_dir_e          start_dir, dir;

  assign start_dir = start_rd ? DIR_TO_SP : DIR_FROM_SP;

  sdma_seq #(
    .OFF_W(OFF_W), .DADDR_W(DADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .SKIP_W(SKIP_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_rd | start_wr),
    .start_dir (start_dir),
    .sh_loc    (sh_loc),
    .sh_dram   (sh_dram),
    .len_f     (reg_wdata[LEN_W-1:0]),
    .cnt_f     (reg_wdata[LEN_W+CNT_W-1:LEN_W]),
    .skip_f    (reg_wdata[CTRL_W-1:LEN_W+CNT_W]),
    .beat_ready(beat_ready),
    .busy      (busy),
    .done      (done),
    .accept    (accept),
    .beat      (beat),
    .dir       (dir),
    .bank      (sp_bank),
    .loc_ptr   (sp_addr),
    .dram_ptr  (dram_addr)
  );

  sdma_regs #(
    .OFF_W(OFF_W), .DADDR_W(DADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .SKIP_W(SKIP_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wdata(reg_wdata),
    .wr_loc   (wr_loc),
    .wr_dram  (wr_dram),
    .accept   (accept),
    .done     (done),
    .fin_bank (sp_bank),
    .fin_loc  (sp_addr),
    .fin_dram (dram_addr),
    .sh_loc   (sh_loc),
    .sh_dram  (sh_dram),
    .rd_loc   (rd_loc),
    .rd_dram  (rd_dram),
    .rd_ctrl  (rd_ctrl)
  );

  assign beat_valid = busy;
  assign sp_we      = beat & (dir == DIR_TO_SP);
  assign dram_we    = beat & (dir == DIR_FROM_SP);
  assign sp_wdata   = dram_rdata;
  assign dram_wdata = sp_rdata;
endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
  parameter int OFF_W   = 12,
  parameter int DADDR_W = 24,
  parameter int LEN_W   = 12,
  parameter int CTRL_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               beat_ready,
  input logic               start_rd,
  input logic               start_wr,
  input logic               sp_we,
  input logic               dram_we,
  input logic [OFF_W-1:0]   sp_addr,
  input logic [DADDR_W-1:0] dram_addr,
  input logic [CTRL_W-1:0]  rd_ctrl
);
  localparam logic [LEN_W-1:0] LOW_RB = LEN_W'((1 << LEN_W) - 8);

  assert_start_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sp_addr[2:0] == 3'd0) && (dram_addr[2:0] == 3'd0));

  assert_loc_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && beat_ready |=> !busy || (sp_addr == $past(sp_addr) + 1'b1));

  assert_we_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp_we && dram_we));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_ready |=> busy && $stable(sp_addr) && $stable(dram_addr));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fall_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (start_rd || start_wr) |=> $stable(rd_ctrl));

  assert_ctrl_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rd_ctrl[LEN_W-1:0] == LOW_RB);
endmodule

bind sdma_engine sdma_checker #(
  .OFF_W(OFF_W), .DADDR_W(DADDR_W), .LEN_W(LEN_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .beat_ready(beat_ready),
  .start_rd  (start_rd),
  .start_wr  (start_wr),
  .sp_we     (sp_we),
  .dram_we   (dram_we),
  .sp_addr   (sp_addr),
  .dram_addr (dram_addr),
  .rd_ctrl   (rd_ctrl)
);

// File: tb/sdma_engine_tb.sv
module sdma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        wr_loc = 1'b0, wr_dram = 1'b0, start_rd = 1'b0, start_wr = 1'b0;
  logic        busy, done, beat_valid;
  logic        beat_ready = 1'b0;
  logic        sp_bank, sp_we, dram_we;
  logic [11:0] sp_addr;
  logic [7:0]  sp_wdata, sp_rdata, dram_wdata, dram_rdata;
  logic [23:0] dram_addr, rd_dram;
  logic [12:0] rd_loc;
  logic [31:0] rd_ctrl;

  int n_chk = 0;
  int n_bad = 0;
  logic [12:0] vis_loc = '0;
  logic [23:0] vis_dram = '0;

  always #4 clk = ~clk;

  function automatic logic [7:0] dpat(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] spat(logic b, logic [11:0] a);
    return a[7:0] ^ {a[11:8], 3'b000, b} ^ 8'hC3;
  endfunction

  assign dram_rdata = dpat(dram_addr);
  assign sp_rdata   = spat(sp_bank, sp_addr);

  sdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wdata(reg_wdata), .wr_loc(wr_loc), .wr_dram(wr_dram),
    .start_rd(start_rd), .start_wr(start_wr), .busy(busy), .done(done),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .sp_bank(sp_bank), .sp_addr(sp_addr),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata), .dram_addr(dram_addr),
    .dram_we(dram_we), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .rd_loc(rd_loc), .rd_dram(rd_dram), .rd_ctrl(rd_ctrl)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic xfer(input bit rd, input logic [12:0] loc, input logic [23:0] dram,
                      input logic [11:0] len, input logic [7:0] cnt, input logic [11:0] skip,
                      input int stall, input bit poke);
    int rowlen = ((int'(len) >> 3) + 1) * 8;
    int rows = int'(cnt) + 1;
    logic [11:0] l = {loc[11:3], 3'b000};
    logic [23:0] d = {dram[23:3], 3'b000};
    logic [31:0] word = {skip, cnt, len};
    @(negedge clk);
    reg_wdata = 32'(loc); wr_loc = 1'b1;
    @(negedge clk);
    wr_loc = 1'b0; reg_wdata = 32'(dram); wr_dram = 1'b1;
    @(negedge clk);
    wr_dram = 1'b0;
    // R10: shadow writes leave visible readback alone
    chk(rd_loc == vis_loc, "R10 rd_loc after shadow write", 64'(rd_loc), 64'(vis_loc));
    chk(rd_dram == vis_dram, "R10 rd_dram after shadow write", 64'(rd_dram), 64'(vis_dram));
    reg_wdata = word; start_rd = rd; start_wr = !rd;
    @(negedge clk);
    start_rd = 1'b0; start_wr = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    chk(rd_ctrl == word, "R11 ctrl readback after start", 64'(rd_ctrl), 64'(word));
    for (int r = 0; r < rows; r++) begin
      for (int j = 0; j < rowlen; j++) begin
        logic [23:0] ed = d + 24'(j);
        if (stall != 0 && ((r + j) % stall) == 0) begin
          beat_ready = 1'b0; #1;
          chk(!sp_we && !dram_we, "R7 no write while stalled", {62'd0, sp_we, dram_we}, 64'd0);
          chk(sp_addr == l && dram_addr == ed, "R7 address hold", {28'd0, sp_addr, dram_addr}, {28'd0, l, ed});
          @(negedge clk);
        end
        beat_ready = 1'b1;
        if (poke && r == 0 && j == 1) begin
          reg_wdata = 32'hFFFF_FFFF; start_wr = 1'b1; start_rd = 1'b1;
        end
        #1;
        chk(beat_valid && busy, "R2 beat offered", {62'd0, beat_valid, busy}, 64'd3);
        if (r == 0 && j == 0) begin
          chk(sp_addr[2:0] == 3'd0 && dram_addr[2:0] == 3'd0, "R3 first beat aligned",
              {28'd0, sp_addr, dram_addr}, {28'd0, l, ed});
        end
        chk(sp_addr == l && sp_bank == loc[12], "R4 scratchpad address/bank",
            {51'd0, sp_bank, sp_addr}, {51'd0, loc[12], l});
        chk(dram_addr == ed, "R5 dram address", 64'(dram_addr), 64'(ed));
        if (rd) begin
          chk(sp_we && !dram_we && sp_wdata == dpat(ed), "R6 read path byte",
              {54'd0, sp_we, dram_we, sp_wdata}, {54'd0, 2'b10, dpat(ed)});
        end else begin
          chk(dram_we && !sp_we && dram_wdata == spat(loc[12], l), "R6 write path byte",
              {54'd0, sp_we, dram_we, dram_wdata}, {54'd0, 2'b01, spat(loc[12], l)});
        end
        @(negedge clk);
        if (poke && r == 0 && j == 1) begin
          start_wr = 1'b0; start_rd = 1'b0; reg_wdata = '0;
          chk(rd_ctrl == word, "R9 start while busy ignored", 64'(rd_ctrl), 64'(word));
        end
        l = l + 12'd1;
      end
      if (r == rows - 1) d = (d + 24'(rowlen)) & 24'hFFFFF8;
      else d = (d + 24'(rowlen) + 24'(skip)) & 24'hFFFFF8;
    end
    beat_ready = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R8 done after last beat (R2 row count)",
        {62'd0, done, busy}, 64'd2);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", 64'(done), 64'd0);
    vis_loc = {loc[12], l};
    vis_dram = d;
    chk(rd_loc == vis_loc, "R10 final scratchpad readback", 64'(rd_loc), 64'(vis_loc));
    chk(rd_dram == vis_dram, "R10 final dram readback", 64'(rd_dram), 64'(vis_dram));
    chk(rd_ctrl == {skip, 20'h00FF8}, "R11 ctrl readback after done", 64'(rd_ctrl), 64'({skip, 20'h00FF8}));
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [11:0] lens [4] = '{12'd0, 12'd5, 12'd8, 12'd23};
    logic [11:0] skips [2] = '{12'd0, 12'd3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 idle after reset", {62'd0, busy, done}, 64'd0);
    chk(rd_loc == '0 && rd_dram == '0 && rd_ctrl == '0, "R1 readback zero after reset",
        {3'd0, rd_loc, rd_dram}, 64'd0);
    for (int dirv = 0; dirv < 2; dirv++)
      for (int li = 0; li < 4; li++)
        for (int c = 0; c < 3; c++)
          for (int si = 0; si < 2; si++)
            xfer(dirv[0], 13'(13'h0A3 + 13'(li * 517 + c * 4096)), 24'(24'h01_2345 + 24'(c * 77 + si)),
                 lens[li], 8'(c), skips[si], 0, 1'b0);
    // R4 wrap within 4 KiB, bank 1
    xfer(1'b1, 13'h1FF3, 24'h00_0100, 12'd31, 8'd1, 12'd9, 0, 1'b0);
    // R5 DRAM wraps at 2^24
    xfer(1'b0, 13'h0FF8, 24'hFF_FFF5, 12'd15, 8'd2, 12'd21, 0, 1'b0);
    // R7 back-pressure, both directions
    xfer(1'b1, 13'h0040, 24'h00_4000, 12'd9, 8'd2, 12'd5, 3, 1'b0);
    xfer(1'b0, 13'h1044, 24'h00_7007, 12'd7, 8'd1, 12'd1, 2, 1'b0);
    // R9 stray start while busy
    xfer(1'b1, 13'h0200, 24'h10_0000, 12'd15, 8'd1, 12'd4, 0, 1'b1);
    xfer(1'b0, 13'h1200, 24'h20_0000, 12'd15, 8'd0, 12'd4, 4, 1'b1);
    finish_run();
  end
endmodule